// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block is the code-fetch half of a 16-bit processor's bus interface. It keeps a code segment value and a fetch offset, turns them into a 20-bit physical address, and reads code ahead of the execution side over a 16-bit memory port with a request/acknowledge handshake. Fetched bytes go into a six-entry byte FIFO. The execution side drains that FIFO one byte at a time through a valid/ready port.

Fetches are alignment aware. An even offset brings in a whole word in one bus cycle. An odd offset brings in only the byte at that address, so every later fetch is word aligned. A fetch is issued only when the queue has room for everything it will return. A branch or other redirect uses the flush input. Flush clears the queue, loads a new segment and offset, and drops the data of any fetch still in flight.

Top module: `code_prefetch_queue`

## Requirements
- R1: While reset is held, `byte_valid_o` and `mem_req_o` are low. After reset the segment and the offset are zero, so the first fetch is a word fetch at physical address 0.
- R2: A fetch address equals (segment << 4) + offset, taken modulo 2^20. A carry out of bit 19 is lost.
- R3: At an even offset the block issues a word fetch (`mem_word_o` = 1). It queues `mem_rdata_i[7:0]` first and then `mem_rdata_i[15:8]`, and the offset advances by 2.
- R4: At an odd offset the block issues a byte fetch (`mem_word_o` = 0). It queues only `mem_rdata_i[15:8]`, ignores `mem_rdata_i[7:0]`, and the offset advances by 1.
- R5: A word fetch is issued only when at least 2 of the 6 entries are free. A byte fetch needs 1 free entry. The queue never holds more than 6 bytes. For example, with no consumer, an odd start offset stops the fill at 5 bytes.
- R6: Bytes leave in the order they were fetched. `byte_valid_o` is high exactly when the queue is non-empty. A byte is removed on a clock edge where both `byte_valid_o` and `byte_ready_i` are high.
- R7: `mem_req_o`, `mem_addr_o` and `mem_word_o` stay constant from the start of a request until the cycle in which `mem_ack_i` is high. Returned data is taken in that cycle.
- R8: A flush empties the queue by the next cycle and loads the new segment and offset, which the next fetch uses. Data acknowledged for a fetch that was outstanding at, or issued before, the flush is never queued.
- R9: The offset wraps modulo 65536 within the segment. After offset 0xFFFF the next code byte comes from offset 0x0000.
- R10: Fetching does not wait for the consumer. With `byte_ready_i` held low, the queue fills until no further fetch fits, and then no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Redirect: clear the queue and load a new fetch pointer |
| flush_seg_i | input | 16 | New code segment value, used with flush_i |
| flush_off_i | input | 16 | New fetch offset, used with flush_i |
| mem_req_o | output | 1 | Fetch request, held until acknowledged |
| mem_addr_o | output | 20 | Physical fetch address |
| mem_word_o | output | 1 | 1 = word fetch from an even address, 0 = single byte from an odd address |
| mem_ack_i | input | 1 | Fetch complete, read data valid this cycle |
| mem_rdata_i | input | 16 | Read data, even byte on [7:0], odd byte on [15:8] |
| byte_valid_o | output | 1 | A code byte is available |
| byte_data_o | output | 8 | Oldest queued code byte |
| byte_ready_i | input | 1 | Consumer takes the byte this cycle |

## Verification
A request appears one cycle after the block is idle with enough room. Acknowledged bytes appear at the byte port one cycle after the acknowledge edge. A flush shows an empty queue one cycle after the edge that samples it.

The bench drives all inputs and reads all outputs at the falling edge. Each of those results is therefore examined half a cycle after the rising edge that makes it, and never in the same cycle as its cause. Fills and drains are judged only after waits far longer than the slowest memory latency used. Every popped byte and every request is compared on arrival against an arithmetic model of the fetch and consume pointers.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [0:0] {
    FETCH_IDLE = 1'b0,
    FETCH_BUSY = 1'b1
  } fetch_state_e;

  typedef struct packed {
    logic [7:0] first;
    logic [7:0] second;
    logic       two;
  } push_bytes_t;
endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned PA_W      = 20,
  parameter int unsigned SEG_SHIFT = 4,
  parameter logic [SEG_W-1:0] RST_SEG = '0,
  parameter logic [OFF_W-1:0] RST_OFF = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             adv_i,
  input  logic             adv_two_i,
  output logic [PA_W-1:0]  phys_o,
  output logic             odd_o
);
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] step;

  assign step = adv_two_i ? OFF_W'(2) : OFF_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= RST_SEG;
      off_q <= RST_OFF;
    end else if (load_i) begin
      seg_q <= seg_i;
      off_q <= off_i;
    end else if (adv_i) begin
      off_q <= off_q + step;  // wraps within the segment
    end
  end

  assign phys_o = (PA_W'(seg_q) << SEG_SHIFT) + PA_W'(off_q);
  assign odd_o  = off_q[0];

  // R9: advancing never leaves the offset range silently: the low bit tracks the step
  a_r9_odd_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !adv_two_i) |=> (off_q[0] != $past(off_q[0])));
endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             push_two_i,
  input  logic [DW-1:0]    din0_i,
  input  logic [DW-1:0]    din1_i,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic             nonempty_o,
  output logic [CNT_W-1:0] free_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q, wr1, wr2, rd1;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] n_in, n_out;
  logic             do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign wr1    = ptr_inc(wr_q);
  assign wr2    = ptr_inc(wr1);
  assign rd1    = ptr_inc(rd_q);
  assign do_pop = pop_i && (cnt_q != '0);
  assign n_in   = push_i ? (push_two_i ? CNT_W'(2) : CNT_W'(1)) : '0;
  assign n_out  = do_pop ? CNT_W'(1) : '0;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && !clr_i) begin
        if (wr_q == PTR_W'(g))                   mem_q[g] <= din0_i;
        else if (push_two_i && wr1 == PTR_W'(g)) mem_q[g] <= din1_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= push_two_i ? wr2 : wr1;
      if (do_pop) rd_q <= rd1;
      cnt_q <= cnt_q + n_in - n_out;
    end
  end

  assign head_o     = mem_q[rd_q];
  assign nonempty_o = (cnt_q != '0);
  assign free_o     = CNT_W'(DEPTH) - cnt_q;

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (int'(cnt_q) + int'(n_in) <= int'(DEPTH)));
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clr_i) |-> nonempty_o);
  a_r8_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
  import pfq_pkg::*;
#(
  parameter int unsigned PA_W  = 20,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] free_i,
  input  logic             odd_i,
  input  logic [PA_W-1:0]  phys_i,
  input  logic             mem_ack_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic             mem_word_o,
  output logic             accept_o
);
  fetch_state_e     state_q;
  logic             discard_q;
  logic [PA_W-1:0]  addr_q;
  logic             word_q;
  logic [CNT_W-1:0] need;
  logic             issue;
  logic             busy;

  assign busy  = (state_q == FETCH_BUSY);
  assign need  = odd_i ? CNT_W'(1) : CNT_W'(2);
  assign issue = !busy && !flush_i && (free_i >= need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= FETCH_IDLE;
      discard_q <= 1'b0;
      addr_q    <= '0;
      word_q    <= 1'b0;
    end else if (issue) begin
      state_q   <= FETCH_BUSY;
      discard_q <= 1'b0;
      addr_q    <= phys_i;
      word_q    <= !odd_i;
    end else if (busy) begin
      if (mem_ack_i) begin
        state_q   <= FETCH_IDLE;
        discard_q <= 1'b0;
      end else if (flush_i) begin
        discard_q <= 1'b1;  // stale fetch: finish the handshake, drop the data
      end
    end
  end

  assign mem_req_o  = busy;
  assign mem_addr_o = addr_q;
  assign mem_word_o = word_q;
  assign accept_o   = busy && mem_ack_i && !discard_q && !flush_i;

  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_word_o)));
  a_r4_odd_is_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_addr_o[0]) |-> !mem_word_o);
  a_r8_no_issue_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !mem_req_o) |=> !mem_req_o);
  a_r5_room_at_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && !flush_i && free_i >= CNT_W'(2)) |=> mem_req_o);
endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH     = 6,
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned PA_W      = 20,
  parameter int unsigned SEG_SHIFT = 4,
  parameter int unsigned BUS_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [SEG_W-1:0] flush_seg_i,
  input  logic [OFF_W-1:0] flush_off_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic             mem_word_o,
  input  logic             mem_ack_i,
  input  logic [BUS_W-1:0] mem_rdata_i,
  output logic             byte_valid_o,
  output logic [7:0]       byte_data_o,
  input  logic             byte_ready_i
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned LANE  = BUS_W / 2;

  logic [PA_W-1:0]  phys;
  logic             odd;
  logic             accept;
  logic [CNT_W-1:0] free;
  logic             nonempty;
  push_bytes_t      pb;

  // even byte on the low lane, odd byte on the high lane
  always_comb begin
    pb.two    = mem_word_o;
    pb.first  = mem_word_o ? mem_rdata_i[LANE-1:0] : mem_rdata_i[BUS_W-1:LANE];
    pb.second = mem_rdata_i[BUS_W-1:LANE];
  end

  pfq_addr_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .SEG_SHIFT(SEG_SHIFT)
  ) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (flush_i),
    .seg_i    (flush_seg_i),
    .off_i    (flush_off_i),
    .adv_i    (accept),
    .adv_two_i(mem_word_o),
    .phys_o   (phys),
    .odd_o    (odd)
  );

  pfq_fetch_ctrl #(.PA_W(PA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .free_i    (free),
    .odd_i     (odd),
    .phys_i    (phys),
    .mem_ack_i (mem_ack_i),
    .mem_req_o (mem_req_o),
    .mem_addr_o(mem_addr_o),
    .mem_word_o(mem_word_o),
    .accept_o  (accept)
  );

  pfq_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (flush_i),
    .push_i    (accept),
    .push_two_i(pb.two),
    .din0_i    (pb.first),
    .din1_i    (pb.second),
    .pop_i     (byte_valid_o && byte_ready_i),
    .head_o    (byte_data_o),
    .nonempty_o(nonempty),
    .free_o    (free)
  );

  assign byte_valid_o = nonempty;

  a_r8_flush_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !byte_valid_o);
  a_r6_hold_when_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i && !flush_i) |=> (byte_valid_o && $stable(byte_data_o)));
endmodule

// File: tb/code_prefetch_queue_bench.sv
`timescale 1ns/1ps
module code_prefetch_queue_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic [15:0] flush_seg_i = '0;
  logic [15:0] flush_off_i = '0;
  logic        mem_req_o;
  logic [19:0] mem_addr_o;
  logic        mem_word_o;
  logic        mem_ack_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;
  logic        byte_valid_o;
  logic [7:0]  byte_data_o;
  logic        byte_ready_i = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  code_prefetch_queue u_code_prefetch_queue (.*);

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // bench-side models
  logic [15:0] f_cs = '0, f_ip = '0;  // fetch pointer
  logic [15:0] c_cs = '0, c_ip = '0;  // consume pointer
  int          lat = 1;
  bit          mem_stall = 0;
  bit          in_service = 0;
  bit          discard = 0;
  bit          cur_word = 0;
  logic [19:0] cur_addr = '0;
  int          wait_cnt = 0;

  function automatic logic [19:0] phys_of(input logic [15:0] s, input logic [15:0] o);
    return ({4'h0, s} << 4) + {4'h0, o};
  endfunction

  function automatic logic [7:0] byte_at(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h5};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      report();
      $finish;
    end
  end

  // memory responder
  initial begin
    wait (rst_ni);
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
        if (!discard) f_ip = f_ip + (cur_word ? 16'd2 : 16'd1);
        in_service = 0;
        discard = 0;
      end else if (in_service) begin
        if (wait_cnt > 0) wait_cnt--;
        else if (!mem_stall) begin
          mem_ack_i = 1'b1;
          mem_rdata_i = cur_word ? {byte_at(cur_addr + 20'd1), byte_at(cur_addr)}
                                 : {byte_at(cur_addr), ~byte_at(cur_addr)};
        end
      end else if (mem_req_o) begin
        chk(mem_addr_o == phys_of(f_cs, f_ip), "R2 fetch address", mem_addr_o, phys_of(f_cs, f_ip));
        chk(mem_word_o == !f_ip[0], "R3/R4 fetch size", mem_word_o, !f_ip[0]);
        in_service = 1;
        cur_addr = mem_addr_o;
        cur_word = mem_word_o;
        wait_cnt = lat;
        if (lat == 0 && !mem_stall) begin
          mem_ack_i = 1'b1;
          mem_rdata_i = cur_word ? {byte_at(cur_addr + 20'd1), byte_at(cur_addr)}
                                 : {byte_at(cur_addr), ~byte_at(cur_addr)};
        end
      end
    end
  end

  task automatic check_byte();
    logic [7:0] e;
    e = byte_at(phys_of(c_cs, c_ip));
    chk(byte_data_o == e, "R6 byte order/R9 wrap", byte_data_o, e);
    c_ip = c_ip + 16'd1;
  endtask

  task automatic pop_n(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk_i);
      if (byte_valid_o) begin
        check_byte();
        byte_ready_i = 1'b1;
        k++;
      end else byte_ready_i = 1'b0;
    end
    @(negedge clk_i);
    byte_ready_i = 1'b0;
  endtask

  task automatic drain(output int n);
    n = 0;
    forever begin
      @(negedge clk_i);
      if (byte_valid_o) begin
        check_byte();
        byte_ready_i = 1'b1;
        n++;
      end else begin
        byte_ready_i = 1'b0;
        break;
      end
    end
  endtask

  task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
    @(negedge clk_i);
    #1;
    flush_i = 1'b1;
    flush_seg_i = s;
    flush_off_i = o;
    f_cs = s; f_ip = o; c_cs = s; c_ip = o;
    if (in_service) discard = 1;
    @(negedge clk_i);
    #1;
    flush_i = 1'b0;
  endtask

  task automatic fill_check(input logic [15:0] s, input logic [15:0] o, input int exp_cnt);
    int got;
    byte_ready_i = 1'b0;
    do_flush(s, o);
    repeat (60) @(negedge clk_i);
    #1;
    chk(mem_req_o == 1'b0, "R10 no request once full", mem_req_o, 0);
    chk(byte_valid_o == 1'b1, "R10 filled without consumer", byte_valid_o, 1);
    mem_stall = 1;
    drain(got);
    chk(got == exp_cnt, "R5 fill level", got, exp_cnt);
    #1;
    mem_stall = 0;
    pop_n(12);
  endtask

  initial begin
    logic [15:0] segs [3];
    logic [15:0] offs [8];
    segs = '{16'h0000, 16'h1234, 16'hFFFF};
    offs = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
             16'hFFFC, 16'hFFFD, 16'hFFFE, 16'hFFFF};
    repeat (3) @(negedge clk_i);
    chk(byte_valid_o == 1'b0, "R1 reset valid", byte_valid_o, 0);
    chk(mem_req_o == 1'b0, "R1 reset request", mem_req_o, 0);
    rst_ni = 1'b1;
    while (!mem_req_o) @(negedge clk_i);
    chk(mem_addr_o == 20'h0, "R1 first fetch address", mem_addr_o, 0);
    chk(mem_word_o == 1'b1, "R1 first fetch is word", mem_word_o, 1);
    pop_n(30);

    // sweep: latency x segment x start offset (alignment, 20-bit and 16-bit wrap)
    for (int l = 0; l < 4; l++) begin
      for (int si = 0; si < 3; si++) begin
        for (int oi = 0; oi < 8; oi++) begin
          #1 lat = l;
          do_flush(segs[si], offs[oi]);
          pop_n(14);  // R2 R3 R4 R9
        end
      end
    end

    // R5 / R10: fill levels with no consumer
    lat = 2;
    fill_check(16'h0400, 16'h0010, 6);
    fill_check(16'h0400, 16'h0011, 5);
    fill_check(16'hFFFF, 16'hFFFF, 5);

    // R8: flush while a fetch is in flight
    #1 lat = 6;
    do_flush(16'h0100, 16'h0000);
    while (!(mem_req_o && in_service)) @(negedge clk_i);
    do_flush(16'hABCD, 16'h0037);
    chk(byte_valid_o == 1'b0, "R8 queue empty after flush", byte_valid_o, 0);
    pop_n(12);

    // R8: flush with a full queue
    #1 lat = 1;
    byte_ready_i = 1'b0;
    do_flush(16'h2222, 16'h0100);
    repeat (40) @(negedge clk_i);
    chk(byte_valid_o == 1'b1, "R10 queue filled", byte_valid_o, 1);
    do_flush(16'h3333, 16'h0201);
    chk(byte_valid_o == 1'b0, "R8 full queue cleared", byte_valid_o, 0);
    pop_n(20);

    report();
    $finish;
  end
endmodule